// File: doc/BRIEF.md
# Programmable-Timing SPI Master

This block runs one SPI transfer at a time as the bus master. The serial clock comes from the system clock through an 8-bit divider. Each half period of the serial clock lasts a number of system clocks equal to the divider value. When the divider is 0 or 1, the clock generator is off and the block refuses to start.

A transfer begins with a one-cycle `start` pulse, which carries a few per-transfer select bits:
- a lead-delay select;
- a word-length select;
- a trailing-delay select;
- a continue bit.

Each select chooses between a standard value and the value held in the global configuration inputs. The global inputs are:
- the divider;
- the lead count;
- a 4-bit length code;
- a trailing field;
- the clock polarity and phase.

The block then:
1. drives chip select low;
2. waits the lead delay;
3. shifts a word of 8 to 16 bits, most significant bit first;
4. holds chip select through a trailing delay;
5. raises `done` for one cycle together with the received word.

Chip select is released at `done`, unless the continue bit of that transfer asked to keep it low.

Top module: `spi_timing_master`

## Requirements
- R1: During a transfer, every serial-clock half period lasts exactly `cfg_div` system clocks, so the serial clock runs at the system clock divided by 2·`cfg_div`.
- R2: While `cfg_div` is 0 or 1, a `start` pulse is ignored. `busy` stays low, `cs_n` stays high and `sck` stays at the `cfg_cpol` level.
- R3: With `cmd_lead_sel`=1, the first `sck` transition comes `cfg_lead` system clocks after the clock edge that drives `cs_n` low. A lead count of 0 is taken as 1.
- R4: With `cmd_lead_sel`=0, `cfg_lead` is ignored and the lead delay equals one half period (`cfg_div` clocks).
- R5: With `cmd_len_sel`=0, the word is 8 bits whatever the code. With `cmd_len_sel`=1, the 4-bit `cfg_len_code` selects the length:
  - code 4'b0000 gives 16 bits;
  - codes 4'b1000 to 4'b1111 give 8 to 15 bits (8 plus the low three bits).
- R6: With `cmd_len_sel`=1, a code from 4'b0001 to 4'b0111 makes an 8-bit transfer and sets `len_err`. The flag stays set until reset.
- R7: The delay from the last `sck` transition to `done` depends on `cmd_trail_sel`:
  - 0 gives 17 clocks;
  - 1 gives 32·`cfg_trail` clocks, and a field of 0 gives 8192 clocks.
- R8: `sck` rests at `cfg_cpol` when idle. With `cfg_cpha`=0, `mosi` is valid before the leading edge and `miso` is sampled on leading edges. With `cfg_cpha`=1, `mosi` changes on leading edges and `miso` is sampled on trailing edges. Data goes most significant bit first. `rx_data` holds the received bits right-aligned, with zeros above.
- R9: `busy` is high from the clock edge after an accepted `start` until `done`. `done` is a one-cycle pulse in the cycle `busy` falls, with `rx_data` valid in that cycle. A `start` that arrives while busy is ignored and not queued.
- R10: `cs_n` is low from the accepting edge through the trailing delay. It rises together with `done`, unless `cmd_cont` was 1 for that transfer, in which case it stays low until a later transfer ends without continue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div | input | 8 | Half-period length in system clocks; 0 or 1 disables |
| cfg_lead | input | 7 | Programmed lead delay in system clocks |
| cfg_len_code | input | 4 | Programmed word-length code |
| cfg_trail | input | 8 | Programmed trailing delay in units of 32 clocks |
| cfg_cpol | input | 1 | Serial-clock idle level |
| cfg_cpha | input | 1 | Serial-clock phase |
| start | input | 1 | One-cycle transfer request |
| cmd_lead_sel | input | 1 | 1: programmed lead delay, 0: half period |
| cmd_len_sel | input | 1 | 1: length from code, 0: 8 bits |
| cmd_trail_sel | input | 1 | 1: programmed trailing delay, 0: 17 clocks |
| cmd_cont | input | 1 | Keep chip select low after this transfer |
| tx_data | input | 16 | Word to send, right-aligned |
| miso | input | 1 | Serial data from the peripheral |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rx_data | output | 16 | Received word, right-aligned |
| len_err | output | 1 | Sticky reserved-length-code flag |
| cs_n | output | 1 | Active-low peripheral chip select |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the peripheral |

## Verification
The properties assume that `cfg_cpol` holds steady whenever the idle-level check compares `sck` with it, and that reset is held for more than one cycle so every past value they use is a reset value. The bench changes the configuration only while no transfer runs. It then waits idle cycles before the next start, so the idle level settles. It pulses `start` for one cycle, except in the scenario that deliberately pulses it during a transfer. Its peripheral model changes `miso` only on the serial-clock edge opposite the sampling edge. The sampled value is therefore always at least a full half period old.

// File: rtl/spi_tm_pkg.sv
package spi_tm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_TRAIL = 2'd3
  } xfer_st_t;

endpackage

// File: rtl/spi_tm_len_dec.sv
module spi_tm_len_dec #(
  parameter int CODE_W = 4,
  parameter int LEN_W  = 5
) (
  input  logic              sel,
  input  logic [CODE_W-1:0] code,
  output logic [LEN_W-1:0]  nbits,
  output logic              bad
);

  localparam int BASE_LEN = 2 ** (CODE_W - 1);
  localparam int FULL_LEN = 2 * BASE_LEN;

  always_comb begin
    bad   = 1'b0;
    nbits = LEN_W'(BASE_LEN);
    if (sel) begin
      if (code == '0) begin
        nbits = LEN_W'(FULL_LEN);
      end else if (code[CODE_W-1]) begin
        nbits = LEN_W'(BASE_LEN) + LEN_W'(code[CODE_W-2:0]);
      end else begin
        bad = 1'b1;
      end
    end
  end

endmodule

// File: rtl/spi_tm_delay_sel.sv
module spi_tm_delay_sel #(
  parameter int DIV_W      = 8,
  parameter int LEAD_W     = 7,
  parameter int TRAIL_W    = 8,
  parameter int CNT_W      = 14,
  parameter int STD_TRAIL  = 17,
  parameter int TRAIL_UNIT = 32
) (
  input  logic [DIV_W-1:0]   div,
  input  logic [LEAD_W-1:0]  lead,
  input  logic [TRAIL_W-1:0] trail,
  input  logic               lead_sel,
  input  logic               trail_sel,
  output logic [CNT_W-1:0]   lead_load,
  output logic [CNT_W-1:0]   trail_load
);

  localparam int TRAIL_MAX = TRAIL_UNIT * (2 ** TRAIL_W);

  always_comb begin
    if (!lead_sel) begin
      lead_load = CNT_W'(div);
    end else if (lead == '0) begin
      lead_load = CNT_W'(1);
    end else begin
      lead_load = CNT_W'(lead);
    end

    if (!trail_sel) begin
      trail_load = CNT_W'(STD_TRAIL);
    end else if (trail == '0) begin
      trail_load = CNT_W'(TRAIL_MAX);
    end else begin
      trail_load = CNT_W'(trail) * CNT_W'(TRAIL_UNIT);
    end
  end

endmodule

// File: rtl/spi_tm_shift.sv
module spi_tm_shift #(
  parameter int WORD_W = 16,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              cpha,
  input  logic [LEN_W-1:0]  nbits,
  input  logic [WORD_W-1:0] tx,
  input  logic              drive,
  input  logic              sample,
  input  logic              miso,
  output logic              mosi,
  output logic [WORD_W-1:0] rx
);

  logic [WORD_W-1:0] txs;
  logic [LEN_W-1:0]  shamt;
  logic [WORD_W-1:0] aligned;

  assign shamt   = LEN_W'(WORD_W) - nbits;
  assign aligned = tx << shamt;

  always_ff @(posedge clk) begin
    if (rst) begin
      txs  <= '0;
      mosi <= 1'b0;
      rx   <= '0;
    end else if (load) begin
      rx <= '0;
      if (cpha) begin
        txs  <= aligned;
        mosi <= 1'b0;
      end else begin
        txs  <= aligned << 1;
        mosi <= aligned[WORD_W-1];
      end
    end else begin
      if (drive) begin
        mosi <= txs[WORD_W-1];
        txs  <= txs << 1;
      end
      if (sample) begin
        rx <= {rx[WORD_W-2:0], miso};
      end
    end
  end

endmodule

// File: rtl/spi_timing_master.sv
module spi_timing_master
  import spi_tm_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int LEAD_W     = 7,
  parameter int CODE_W     = 4,
  parameter int TRAIL_W    = 8,
  parameter int WORD_W     = 16,
  parameter int STD_TRAIL  = 17,
  parameter int TRAIL_UNIT = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DIV_W-1:0]   cfg_div,
  input  logic [LEAD_W-1:0]  cfg_lead,
  input  logic [CODE_W-1:0]  cfg_len_code,
  input  logic [TRAIL_W-1:0] cfg_trail,
  input  logic               cfg_cpol,
  input  logic               cfg_cpha,
  input  logic               start,
  input  logic               cmd_lead_sel,
  input  logic               cmd_len_sel,
  input  logic               cmd_trail_sel,
  input  logic               cmd_cont,
  input  logic [WORD_W-1:0]  tx_data,
  input  logic               miso,
  output logic               busy,
  output logic               done,
  output logic [WORD_W-1:0]  rx_data,
  output logic               len_err,
  output logic               cs_n,
  output logic               sck,
  output logic               mosi
);

  localparam int LEN_W  = $clog2(WORD_W + 1);
  localparam int CNT_W  = $clog2(TRAIL_UNIT * (2 ** TRAIL_W)) + 1;
  localparam int EDGE_W = $clog2(2 * WORD_W);

  xfer_st_t           state;
  logic [CNT_W-1:0]   cnt;
  logic [EDGE_W-1:0]  edge_idx;
  logic [DIV_W-1:0]   cur_div;
  logic               cur_cpha;
  logic [LEN_W-1:0]   cur_len;
  logic [CNT_W-1:0]   trail_q;
  logic               cont_q;

  logic [LEN_W-1:0]   dec_len;
  logic               dec_bad;
  logic [CNT_W-1:0]   lead_load;
  logic [CNT_W-1:0]   trail_load;
  logic [WORD_W-1:0]  rx_word;

  logic               div_on;
  logic               accept;
  logic               edge_fire;
  logic [EDGE_W-1:0]  cur_edge;
  logic [EDGE_W-1:0]  last_edge;
  logic               drive;
  logic               sample;

  assign div_on    = cfg_div > DIV_W'(1);
  assign accept    = (state == ST_IDLE) && start && div_on;
  assign edge_fire = ((state == ST_LEAD) || (state == ST_SHIFT)) && (cnt == CNT_W'(1));
  assign cur_edge  = (state == ST_LEAD) ? '0 : edge_idx;
  assign last_edge = EDGE_W'(({1'b0, cur_len} << 1) - (LEN_W + 1)'(1));
  assign drive     = edge_fire && (cur_edge[0] != cur_cpha);
  assign sample    = edge_fire && (cur_edge[0] == cur_cpha);

  spi_tm_len_dec #(
    .CODE_W (CODE_W),
    .LEN_W  (LEN_W)
  ) i_len_dec (
    .sel   (cmd_len_sel),
    .code  (cfg_len_code),
    .nbits (dec_len),
    .bad   (dec_bad)
  );

  spi_tm_delay_sel #(
    .DIV_W      (DIV_W),
    .LEAD_W     (LEAD_W),
    .TRAIL_W    (TRAIL_W),
    .CNT_W      (CNT_W),
    .STD_TRAIL  (STD_TRAIL),
    .TRAIL_UNIT (TRAIL_UNIT)
  ) i_delay_sel (
    .div        (cfg_div),
    .lead       (cfg_lead),
    .trail      (cfg_trail),
    .lead_sel   (cmd_lead_sel),
    .trail_sel  (cmd_trail_sel),
    .lead_load  (lead_load),
    .trail_load (trail_load)
  );

  spi_tm_shift #(
    .WORD_W (WORD_W),
    .LEN_W  (LEN_W)
  ) i_shift (
    .clk    (clk),
    .rst    (rst),
    .load   (accept),
    .cpha   (cfg_cpha),
    .nbits  (dec_len),
    .tx     (tx_data),
    .drive  (drive),
    .sample (sample),
    .miso   (miso),
    .mosi   (mosi),
    .rx     (rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      edge_idx <= '0;
      cur_div  <= '0;
      cur_cpha <= 1'b0;
      cur_len  <= '0;
      trail_q  <= '0;
      cont_q   <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      rx_data  <= '0;
      len_err  <= 1'b0;
      cs_n     <= 1'b1;
      sck      <= cfg_cpol;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          sck <= cfg_cpol;
          if (accept) begin
            state    <= ST_LEAD;
            busy     <= 1'b1;
            cs_n     <= 1'b0;
            cnt      <= lead_load;
            edge_idx <= '0;
            cur_div  <= cfg_div;
            cur_cpha <= cfg_cpha;
            cur_len  <= dec_len;
            trail_q  <= trail_load;
            cont_q   <= cmd_cont;
            if (dec_bad) begin
              len_err <= 1'b1;
            end
          end
        end
        ST_LEAD: begin
          if (edge_fire) begin
            sck      <= ~sck;
            cnt      <= CNT_W'(cur_div);
            edge_idx <= EDGE_W'(1);
            state    <= ST_SHIFT;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_SHIFT: begin
          if (edge_fire) begin
            sck <= ~sck;
            if (edge_idx == last_edge) begin
              cnt   <= trail_q;
              state <= ST_TRAIL;
            end else begin
              cnt      <= CNT_W'(cur_div);
              edge_idx <= edge_idx + EDGE_W'(1);
            end
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_TRAIL: begin
          if (cnt == CNT_W'(1)) begin
            state   <= ST_IDLE;
            busy    <= 1'b0;
            done    <= 1'b1;
            rx_data <= rx_word;
            cs_n    <= ~cont_q;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_tm_checks.sv
module spi_tm_checks #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [DIV_W-1:0] cfg_div,
  input logic             cfg_cpol,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             len_err,
  input logic             cs_n,
  input logic             sck
);

  AST_DIV_OFF_NO_START: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (cfg_div < DIV_W'(2))) |=> !busy); // R2

  AST_CS_LOW_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !cs_n); // R10

  AST_CS_RISE_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> done); // R10

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy))); // R9

  AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> (sck == $past(cfg_cpol))); // R8

  AST_LEN_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    len_err |=> len_err); // R6

endmodule

bind spi_timing_master spi_tm_checks #(.DIV_W(DIV_W)) i_spi_tm_checks (
  .clk      (clk),
  .rst      (rst),
  .cfg_div  (cfg_div),
  .cfg_cpol (cfg_cpol),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .len_err  (len_err),
  .cs_n     (cs_n),
  .sck      (sck)
);

// File: tb/test_spi_timing_master.sv
`timescale 1ns/1ps
module test_spi_timing_master;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cfg_div = 8'd2;
  logic [6:0]  cfg_lead = 7'd1;
  logic [3:0]  cfg_len_code = 4'd0;
  logic [7:0]  cfg_trail = 8'd1;
  logic        cfg_cpol = 1'b0;
  logic        cfg_cpha = 1'b0;
  logic        start = 1'b0;
  logic        cmd_lead_sel = 1'b0;
  logic        cmd_len_sel = 1'b0;
  logic        cmd_trail_sel = 1'b0;
  logic        cmd_cont = 1'b0;
  logic [15:0] tx_data = 16'h0;
  logic        miso = 1'b0;
  logic        busy, done, len_err, cs_n, sck, mosi;
  logic [15:0] rx_data;

  int n_chk = 0;
  int n_fail = 0;

  logic [15:0] sl_al = 16'h0;
  logic [15:0] sl_rx = 16'h0;
  logic        sl_act = 1'b0;

  always #2.5 clk = ~clk;

  spi_timing_master i_spi_timing_master (
    .clk(clk), .rst(rst), .cfg_div(cfg_div), .cfg_lead(cfg_lead),
    .cfg_len_code(cfg_len_code), .cfg_trail(cfg_trail), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .start(start), .cmd_lead_sel(cmd_lead_sel),
    .cmd_len_sel(cmd_len_sel), .cmd_trail_sel(cmd_trail_sel), .cmd_cont(cmd_cont),
    .tx_data(tx_data), .miso(miso), .busy(busy), .done(done), .rx_data(rx_data),
    .len_err(len_err), .cs_n(cs_n), .sck(sck), .mosi(mosi)
  );

  // Peripheral model: shifts out on the edge opposite to the one it samples on.
  always @(sck) begin
    if (sl_act && cs_n === 1'b0) begin
      if (sck !== cfg_cpol) begin
        if (!cfg_cpha) sl_rx = {sl_rx[14:0], mosi};
        else begin miso = sl_al[15]; sl_al = sl_al << 1; end
      end else begin
        if (!cfg_cpha) begin miso = sl_al[15]; sl_al = sl_al << 1; end
        else sl_rx = {sl_rx[14:0], mosi};
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int f_len(logic sel, logic [3:0] code);
    if (!sel) return 8;
    if (code == 4'd0) return 16;
    if (code[3]) return 8 + int'(code[2:0]);
    return 8;
  endfunction

  // One transfer with the current configuration; inj > 0 pulses start again in that cycle.
  task automatic run_xfer(string tag, int inj, logic [15:0] tx, logic [15:0] stx);
    int len, lead_n, trail_n, total_n, mask;
    int cycles, toggles, lead_m, half_m, done_at;
    logic prev;
    logic exp_err;
    len     = f_len(cmd_len_sel, cfg_len_code);
    lead_n  = cmd_lead_sel ? ((cfg_lead == 0) ? 1 : int'(cfg_lead)) : int'(cfg_div);
    trail_n = cmd_trail_sel ? ((cfg_trail == 0) ? 8192 : 32 * int'(cfg_trail)) : 17;
    total_n = lead_n + (2 * len - 1) * int'(cfg_div) + trail_n;
    mask    = (1 << len) - 1;
    exp_err = len_err | (cmd_len_sel && cfg_len_code != 4'd0 && !cfg_len_code[3]);
    @(negedge clk);
    @(negedge clk);
    sl_al = 16'(stx << (16 - len));
    sl_rx = 16'h0;
    if (!cfg_cpha) begin miso = sl_al[15]; sl_al = sl_al << 1; end
    sl_act = 1'b1;
    tx_data = tx;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9", {tag, " busy after start"}, busy, 1);
    chk("R10", {tag, " cs_n low after start"}, cs_n, 0);
    cycles = 0; toggles = 0; lead_m = -1; half_m = -1; done_at = -1;
    prev = sck;
    while (cycles < 12000) begin
      @(negedge clk);
      cycles++;
      if (inj > 0 && cycles == inj) begin tx_data = ~tx; start = 1'b1; end
      else start = 1'b0;
      if (sck != prev) begin
        toggles++;
        if (toggles == 1) lead_m = cycles;
        if (toggles == 2) half_m = cycles - lead_m;
      end
      prev = sck;
      if (busy && cs_n) chk("R10", {tag, " cs_n low while busy"}, cs_n, 0);
      if (done) begin done_at = cycles; break; end
    end
    start = 1'b0;
    chk(cmd_lead_sel ? "R3" : "R4", {tag, " lead delay"}, lead_m, lead_n);
    chk("R1", {tag, " half period"}, half_m, int'(cfg_div));
    chk("R5", {tag, " sck transitions"}, toggles, 2 * len);
    chk("R7", {tag, " start to done"}, done_at, total_n);
    chk("R8", {tag, " rx_data"}, int'(rx_data), int'(stx) & mask);
    chk("R8", {tag, " peripheral received"}, int'(sl_rx) & mask, int'(tx) & mask);
    chk("R8", {tag, " sck back at idle"}, sck, cfg_cpol);
    chk("R10", {tag, " cs_n at done"}, cs_n, cmd_cont ? 0 : 1);
    chk("R6", {tag, " len_err"}, len_err, exp_err);
    sl_act = 1'b0;
    @(negedge clk);
    chk("R9", {tag, " done single pulse"}, done, 0);
    chk("R9", {tag, " idle after done"}, busy, 0);
  endtask

  task automatic t_reset();
    chk("R9", "reset busy", busy, 0);
    chk("R9", "reset done", done, 0);
    chk("R10", "reset cs_n", cs_n, 1);
    chk("R8", "reset sck idle", sck, 0);
    chk("R6", "reset len_err", len_err, 0);
    chk("R8", "reset rx_data", int'(rx_data), 0);
  endtask

  task automatic t_mode0_defaults();
    cfg_cpol = 0; cfg_cpha = 0; cfg_div = 8'd2;
    cmd_lead_sel = 0; cmd_len_sel = 0; cmd_trail_sel = 0; cmd_cont = 0;
    run_xfer("mode0 defaults", 0, 16'h00A5, 16'h003C);
  endtask

  task automatic t_prog_lead_len16();
    cfg_cpol = 0; cfg_cpha = 1; cfg_div = 8'd3; cfg_lead = 7'd5;
    cfg_len_code = 4'b0000; cfg_trail = 8'd2;
    cmd_lead_sel = 1; cmd_len_sel = 1; cmd_trail_sel = 1;
    run_xfer("R3 lead5 len16", 0, 16'hC3A1, 16'h5E97);
  endtask

  task automatic t_mode3_len11();
    cfg_cpol = 1; cfg_cpha = 1; cfg_div = 8'd4; cfg_lead = 7'd100;
    cfg_len_code = 4'b1011;
    cmd_lead_sel = 0; cmd_len_sel = 1; cmd_trail_sel = 0;
    run_xfer("R4 mode3 len11", 0, 16'h05B3, 16'h02CD);
  endtask

  task automatic t_mode2_len15();
    cfg_cpol = 1; cfg_cpha = 0; cfg_div = 8'd2; cfg_lead = 7'd127;
    cfg_len_code = 4'b1111; cfg_trail = 8'd1;
    cmd_lead_sel = 1; cmd_len_sel = 1; cmd_trail_sel = 1;
    run_xfer("R5 mode2 len15", 0, 16'h6D29, 16'h1F0E);
  endtask

  task automatic t_lead_zero_and_sel0_len();
    cfg_cpol = 0; cfg_cpha = 0; cfg_div = 8'd5; cfg_lead = 7'd0;
    cfg_len_code = 4'b0000;
    cmd_lead_sel = 1; cmd_len_sel = 0; cmd_trail_sel = 0;
    run_xfer("R5 code ignored, R3 lead0", 0, 16'hFF96, 16'hAA69);
  endtask

  task automatic t_reserved_code();
    cfg_cpol = 0; cfg_cpha = 1; cfg_div = 8'd2; cfg_len_code = 4'b0011;
    cmd_lead_sel = 0; cmd_len_sel = 1; cmd_trail_sel = 0;
    run_xfer("R6 reserved code", 0, 16'h1234, 16'h00C7);
    cfg_len_code = 4'b1001;
    run_xfer("R6 flag sticky", 0, 16'h0155, 16'h00AA);
  endtask

  task automatic t_trail_max();
    cfg_cpol = 0; cfg_cpha = 0; cfg_div = 8'd2; cfg_trail = 8'd0;
    cmd_lead_sel = 0; cmd_len_sel = 0; cmd_trail_sel = 1;
    run_xfer("R7 trail field 0", 0, 16'h0081, 16'h007E);
  endtask

  task automatic t_div_off();
    int seen_busy, seen_cs, seen_sck;
    seen_busy = 0; seen_cs = 0; seen_sck = 0;
    cfg_cpol = 1; cmd_trail_sel = 0;
    for (int d = 0; d < 2; d++) begin
      cfg_div = 8'(d);
      @(negedge clk);
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 12; k++) begin
        if (busy) seen_busy++;
        if (!cs_n) seen_cs++;
        if (sck != cfg_cpol) seen_sck++;
        @(negedge clk);
      end
    end
    chk("R2", "divider off busy cycles", seen_busy, 0);
    chk("R2", "divider off cs_n low cycles", seen_cs, 0);
    chk("R2", "divider off sck away from idle", seen_sck, 0);
    cfg_cpol = 0;
  endtask

  task automatic t_start_while_busy();
    cfg_cpol = 0; cfg_cpha = 0; cfg_div = 8'd3;
    cmd_lead_sel = 0; cmd_len_sel = 0; cmd_trail_sel = 0;
    run_xfer("R9 start while busy", 20, 16'h00E1, 16'h004B);
  endtask

  task automatic t_continue();
    cfg_cpol = 0; cfg_cpha = 1; cfg_div = 8'd2;
    cmd_lead_sel = 0; cmd_len_sel = 0; cmd_trail_sel = 0; cmd_cont = 1;
    run_xfer("R10 continue", 0, 16'h0033, 16'h00CC);
    repeat (4) @(negedge clk);
    chk("R10", "cs_n held low while idle", cs_n, 0);
    cmd_cont = 0;
    run_xfer("R10 release", 0, 16'h00F0, 16'h000F);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_mode0_defaults();
    t_prog_lead_len16();
    t_mode3_len11();
    t_mode2_len15();
    t_lead_zero_and_sel0_len();
    t_reserved_code();
    t_trail_max();
    t_div_off();
    t_start_while_busy();
    t_continue();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule